// File: doc/BRIEF.md
# Two-Level Virtual Page Translator

This block turns an 18-bit virtual word address into a 19-bit physical word address. The upper 8 address bits select a virtual page and the lower 10 bits are the word offset. Three base registers point at page tables in memory. One covers the low half of user space, one covers the high half of user space, and one covers the high half of executive space. Executive low pages, and all executive pages when executive paging is off, pass through without translation. Every table word holds the entries for two neighbouring pages.

Translated entries are kept in two direct-indexed caches, one for user pages and one for executive high pages. A cached value of zero means the entry has not been loaded. A miss walks memory through a read port with a request and an acknowledge. The walk fills both pages of the fetched word into the cache. The requester sees a one-cycle done strobe with the physical address, or a one-cycle fault strobe with a fault code. A flush input empties both caches at once.

Top module: `page_xlate`

## Requirements
- R1: After reset, ready_o is 1 and done_o, fault_o and mem_req_o are 0. All three base registers and both caches are empty, so the first translation walks memory at table address 0.
- R2: The page is addr[17:10] and the offset is addr[9:0]. A successful translation returns phys = {entry[8:0], offset}.
- R3: An executive-mode request (req_user_i=0) passes through untranslated, with phys = addr, when page bit 7 is 0 or exec_map_en_i is 0. It makes no memory access and strobes done_o in the cycle after acceptance.
- R4: The base register is chosen by mode and page bit 7: user with bit 7 clear uses code 0, user with bit 7 set uses code 1, executive with bit 7 set uses code 2. A load with code 3 changes nothing. Base register data is {length[6:0], table_base[18:0]}. The table word address is table_base + page[6:1].
- R5: When page[6:1] is greater than the length field on a cache miss, fault_o is strobed with code 0x80 in the cycle after acceptance and no memory read is made. Equality is allowed.
- R6: An odd page takes its entry from bits [35:18] of the table word, and an even page takes it from bits [17:0].
- R7: A nonzero cached entry is used directly, without a length check or a memory read, with the result in the cycle after acceptance. A walk writes both entries of the fetched word, so the partner page then hits.
- R8: When req_fetch_i and req_pure_i are both 1, entry bits [17:16] must be 01. Any other value strobes fault_o with code 0x10. The check is skipped when either flag is 0, and it applies to cached and freshly walked entries alike.
- R9: mem_req_o stays high with a stable mem_addr_o until mem_ack_i. ready_o is low for the whole walk. The result strobe follows one cycle after the acknowledge.
- R10: flush_i zeroes every entry of both caches, so later requests walk again.
- R11: A request accepted in the same cycle as flush_i treats the cache as empty and walks. A flush in the acknowledge cycle wins over the refill: the translation is still returned, but neither entry is kept.
- R12: Each accepted request produces exactly one single-cycle strobe, either done_o or fault_o, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request, taken when ready_o is 1 |
| req_addr_i | input | 18 | Virtual word address |
| req_user_i | input | 1 | 1 = user mode, 0 = executive mode |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| req_pure_i | input | 1 | Pure-code checking is enabled |
| ready_o | output | 1 | Block can accept a request |
| exec_map_en_i | input | 1 | Enables translation of executive high pages |
| ld_valid_i | input | 1 | Base register load strobe |
| ld_sel_i | input | 2 | Base register code (0, 1, 2; 3 is ignored) |
| ld_data_i | input | 26 | {length[6:0], table_base[18:0]} |
| flush_i | input | 1 | Empties both caches |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 19 | Table word address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | 36 | Table word, two 18-bit entries |
| done_o | output | 1 | Translation complete strobe |
| fault_o | output | 1 | Translation fault strobe |
| fault_code_o | output | 8 | 0x80 length fault, 0x10 pure-code fault |
| phys_addr_o | output | 19 | Physical word address |

## Verification
A cache flush can land in the same cycle as a lookup, or in the same cycle as the refill of a walk. The bench provokes the first by raising flush_i in the cycle a request is accepted. It provokes the second by watching for the acknowledge and raising flush_i in that cycle. The outcome is judged from the number of memory reads made by the following requests to the same page pair: a flush that loses a race to the refill would show up as a missing read.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
  typedef enum logic [1:0] {
    BSEL_ULO  = 2'd0,
    BSEL_UHI  = 2'd1,
    BSEL_EHI  = 2'd2,
    BSEL_NONE = 2'd3
  } bsel_e;

  typedef enum logic {W_IDLE, W_REQ} walk_st_e;

  localparam int FC_W = 8;
  localparam logic [FC_W-1:0] FC_LEN  = 8'h80;
  localparam logic [FC_W-1:0] FC_PURE = 8'h10;
  localparam logic [1:0]      ACC_PURE_OK = 2'b01;
endpackage

// File: rtl/pt_bregs.sv
`timescale 1ns/1ps
module pt_bregs
  import pt_pkg::*;
#(
  parameter int LEN_W = 7,
  parameter int TBA_W = 19
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ld_en_i,
  input  bsel_e                  ld_sel_i,
  input  logic [LEN_W+TBA_W-1:0] ld_data_i,
  input  bsel_e                  rd_sel_i,
  output logic [LEN_W-1:0]       len_o,
  output logic [TBA_W-1:0]       tba_o
);
  localparam int BR_W = LEN_W + TBA_W;
  localparam int NREG = 3;

  logic [BR_W-1:0] regs_q [NREG];
  logic [BR_W-1:0] rd_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (ld_en_i) begin
      for (int i = 0; i < NREG; i++)
        if (ld_sel_i == bsel_e'(i)) regs_q[i] <= ld_data_i;
    end
  end

  always_comb begin
    rd_val = regs_q[0];
    for (int i = 0; i < NREG; i++)
      if (rd_sel_i == bsel_e'(i)) rd_val = regs_q[i];
  end

  assign len_o = rd_val[BR_W-1:TBA_W];
  assign tba_o = rd_val[TBA_W-1:0];
endmodule

// File: rtl/pt_tlb.sv
`timescale 1ns/1ps
module pt_tlb #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ENT_W-1:0] rd_ent_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-2:0] fill_pair_i,
  input  logic [ENT_W-1:0] fill_even_i,
  input  logic [ENT_W-1:0] fill_odd_i
);
  localparam int N = 1 << IDX_W;

  logic [ENT_W-1:0] ent_q [N];

  // flush beats a refill landing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else if (fill_en_i) begin
      ent_q[{fill_pair_i, 1'b0}] <= fill_even_i;
      ent_q[{fill_pair_i, 1'b1}] <= fill_odd_i;
    end
  end

  assign rd_ent_o = ent_q[rd_idx_i];

  a_r10_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (rd_ent_o == '0));
endmodule

// File: rtl/pt_walk.sv
`timescale 1ns/1ps
module pt_walk
  import pt_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              busy_o,
  output logic              fill_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i
);
  walk_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          st_q   <= W_REQ;
          addr_q <= start_addr_i;
        end
        W_REQ: if (mem_ack_i) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q == W_REQ);
  assign mem_req_o  = (st_q == W_REQ);
  assign mem_addr_o = addr_q;
  assign fill_o     = (st_q == W_REQ) && mem_ack_i;

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r9_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == W_IDLE));
endmodule

// File: rtl/page_xlate.sv
`timescale 1ns/1ps
module page_xlate
  import pt_pkg::*;
#(
  parameter int OFF_W   = 10,
  parameter int PG_W    = 8,
  parameter int FRAME_W = 9,
  parameter int LEN_W   = 7,
  parameter int TBA_W   = 19,
  parameter int MEM_W   = 36
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [PG_W+OFF_W-1:0]  req_addr_i,
  input  logic                   req_user_i,
  input  logic                   req_fetch_i,
  input  logic                   req_pure_i,
  output logic                   ready_o,
  input  logic                   exec_map_en_i,
  input  logic                   ld_valid_i,
  input  logic [1:0]             ld_sel_i,
  input  logic [LEN_W+TBA_W-1:0] ld_data_i,
  input  logic                   flush_i,
  output logic                   mem_req_o,
  output logic [TBA_W-1:0]       mem_addr_o,
  input  logic                   mem_ack_i,
  input  logic [MEM_W-1:0]       mem_data_i,
  output logic                   done_o,
  output logic                   fault_o,
  output logic [FC_W-1:0]        fault_code_o,
  output logic [FRAME_W+OFF_W-1:0] phys_addr_o
);
  localparam int VA_W   = PG_W + OFF_W;
  localparam int PA_W   = FRAME_W + OFF_W;
  localparam int ENT_W  = MEM_W / 2;
  localparam int TIDX_W = PG_W - 2;
  localparam int HI_B   = PG_W - 1;

  function automatic logic pure_bad(input logic [ENT_W-1:0] ent,
                                    input logic fe, input logic pu);
    return fe && pu && (ent[ENT_W-1:ENT_W-2] != ACC_PURE_OK);
  endfunction

  // request decode
  logic [PG_W-1:0]   page;
  logic [OFF_W-1:0]  off;
  logic [TIDX_W-1:0] tidx;
  logic              direct, len_bad, hit, accept, start, busy, fill;
  bsel_e             rd_sel;
  logic [LEN_W-1:0]  blen;
  logic [TBA_W-1:0]  btba, walk_addr;
  logic [ENT_W-1:0]  u_ent, e_ent, cur_ent, new_ent;

  assign page    = req_addr_i[VA_W-1:OFF_W];
  assign off     = req_addr_i[OFF_W-1:0];
  assign tidx    = page[PG_W-2:1];
  assign direct  = !req_user_i && (!page[HI_B] || !exec_map_en_i);
  assign rd_sel  = req_user_i ? (page[HI_B] ? BSEL_UHI : BSEL_ULO) : BSEL_EHI;
  assign len_bad = LEN_W'(tidx) > blen;
  assign walk_addr = btba + TBA_W'(tidx);
  assign cur_ent = req_user_i ? u_ent : e_ent;
  assign hit     = (cur_ent != '0) && !flush_i;
  assign ready_o = !busy;
  assign accept  = req_valid_i && !busy;
  assign start   = accept && !direct && !hit && !len_bad;

  // latched request for the walk
  logic              lat_user, lat_fetch, lat_pure;
  logic [PG_W-1:0]   lat_page;
  logic [OFF_W-1:0]  lat_off;

  assign new_ent = lat_page[0] ? mem_data_i[MEM_W-1:ENT_W] : mem_data_i[ENT_W-1:0];

  pt_bregs #(.LEN_W(LEN_W), .TBA_W(TBA_W)) u_bregs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_en_i   (ld_valid_i),
    .ld_sel_i  (bsel_e'(ld_sel_i)),
    .ld_data_i (ld_data_i),
    .rd_sel_i  (rd_sel),
    .len_o     (blen),
    .tba_o     (btba)
  );

  pt_tlb #(.IDX_W(PG_W), .ENT_W(ENT_W)) u_tlb_user (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .rd_idx_i    (page),
    .rd_ent_o    (u_ent),
    .fill_en_i   (fill && lat_user),
    .fill_pair_i (lat_page[PG_W-1:1]),
    .fill_even_i (mem_data_i[ENT_W-1:0]),
    .fill_odd_i  (mem_data_i[MEM_W-1:ENT_W])
  );

  pt_tlb #(.IDX_W(PG_W-1), .ENT_W(ENT_W)) u_tlb_exec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .rd_idx_i    (page[PG_W-2:0]),
    .rd_ent_o    (e_ent),
    .fill_en_i   (fill && !lat_user),
    .fill_pair_i (lat_page[PG_W-2:1]),
    .fill_even_i (mem_data_i[ENT_W-1:0]),
    .fill_odd_i  (mem_data_i[MEM_W-1:ENT_W])
  );

  pt_walk #(.ADDR_W(TBA_W)) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_addr_i (walk_addr),
    .busy_o       (busy),
    .fill_o       (fill),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i)
  );

  // result register
  logic            done_q, fault_q;
  logic [FC_W-1:0] code_q;
  logic [PA_W-1:0] phys_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      code_q    <= '0;
      phys_q    <= '0;
      lat_user  <= 1'b0;
      lat_fetch <= 1'b0;
      lat_pure  <= 1'b0;
      lat_page  <= '0;
      lat_off   <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (accept) begin
        lat_user  <= req_user_i;
        lat_fetch <= req_fetch_i;
        lat_pure  <= req_pure_i;
        lat_page  <= page;
        lat_off   <= off;
        if (direct) begin
          done_q <= 1'b1;
          code_q <= '0;
          phys_q <= PA_W'(req_addr_i);
        end else if (hit) begin
          phys_q <= {cur_ent[FRAME_W-1:0], off};
          if (pure_bad(cur_ent, req_fetch_i, req_pure_i)) begin
            fault_q <= 1'b1;
            code_q  <= FC_PURE;
          end else begin
            done_q <= 1'b1;
            code_q <= '0;
          end
        end else if (len_bad) begin
          fault_q <= 1'b1;
          code_q  <= FC_LEN;
        end
      end
      if (fill) begin
        phys_q <= {new_ent[FRAME_W-1:0], lat_off};
        if (pure_bad(new_ent, lat_fetch, lat_pure)) begin
          fault_q <= 1'b1;
          code_q  <= FC_PURE;
        end else begin
          done_q <= 1'b1;
          code_q <= '0;
        end
      end
    end
  end

  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign phys_addr_o  = phys_q;

  a_r12_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fault_o);
  a_r12_strobe_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> ($past(accept) || $past(fill)));
  a_r3_direct_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && direct) |=> (done_o && phys_addr_o == PA_W'($past(req_addr_i))));
  a_r7_hit_no_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !direct && hit) |=> (!mem_req_o && (done_o || fault_o)));
  a_r5_len_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !direct && !hit && len_bad) |=>
      (fault_o && fault_code_o == FC_LEN && !mem_req_o));
  a_r8_code_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $onehot(fault_code_o));
  a_r11_flush_walks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && flush_i && !direct && !len_bad) |=> mem_req_o);
endmodule

// File: tb/page_xlate_tb_top.sv
`timescale 1ns/1ps
module page_xlate_tb_top;
  localparam int DLY = 2;
  localparam logic [18:0] ULO_B = 19'h00100;
  localparam logic [18:0] UHI_B = 19'h00240;
  localparam logic [18:0] EHI_B = 19'h00380;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [17:0] req_addr = '0;
  logic        req_user = 1'b0, req_fetch = 1'b0, req_pure = 1'b0;
  logic        ready;
  logic        exec_en = 1'b0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [25:0] ld_data = '0;
  logic        flush = 1'b0;
  logic        mem_req;
  logic [18:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [35:0] mem_data = '0;
  logic        done, fault;
  logic [7:0]  fcode;
  logic [18:0] phys;

  int total = 0, bad = 0, cyc = 0, rd_cnt = 0, wcnt = 0;
  logic [18:0] last_addr;

  always #2.5 clk = ~clk;

  page_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_user_i(req_user),
    .req_fetch_i(req_fetch), .req_pure_i(req_pure), .ready_o(ready),
    .exec_map_en_i(exec_en),
    .ld_valid_i(ld_valid), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
    .flush_i(flush),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_data_i(mem_data),
    .done_o(done), .fault_o(fault), .fault_code_o(fcode), .phys_addr_o(phys)
  );

  function automatic logic [17:0] ent_l(input logic [18:0] a);
    int v;
    logic [31:0] w;
    v = int'(a) * 5 + 1;
    w = v;
    return {a[1:0], 7'h01, w[8:0]};
  endfunction

  function automatic logic [17:0] ent_r(input logic [18:0] a);
    int v;
    logic [31:0] w;
    v = int'(a) * 7 + 2;
    w = v;
    return {a[1:0] ^ 2'b01, 7'h02, w[8:0]};
  endfunction

  function automatic logic [18:0] waddr(input bit user, input int pg);
    logic [18:0] b;
    logic [7:0]  p;
    p = pg[7:0];
    b = user ? (p[7] ? UHI_B : ULO_B) : EHI_B;
    return b + 19'(p[6:1]);
  endfunction

  function automatic logic [17:0] ent_of(input bit user, input int pg);
    return pg[0] ? ent_l(waddr(user, pg)) : ent_r(waddr(user, pg));
  endfunction

  // memory responder
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt == DLY - 1) begin
        mem_ack   <= 1'b1;
        mem_data  <= {ent_l(mem_addr), ent_r(mem_addr)};
        last_addr <= mem_addr;
        rd_cnt    <= rd_cnt + 1;
        wcnt      <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  bit          r_done, r_fault, r_rdy_bad, r_dbl, r_notready;
  logic [7:0]  r_code;
  logic [18:0] r_phys;
  int          r_reads, r_lat;

  task automatic txn(input bit user, input int pg, input int off, input bit fe,
                     input bit pu, input bit fl_acc, input bit fl_ack);
    int r0;
    logic [31:0] pw, ow;
    pw = pg; ow = off;
    @(negedge clk);
    r_notready = !ready;
    r0 = rd_cnt;
    last_addr = 19'h7ffff;
    req_user = user; req_fetch = fe; req_pure = pu;
    req_addr = {pw[7:0], ow[9:0]};
    req_valid = 1'b1;
    flush = fl_acc;
    @(negedge clk);
    req_valid = 1'b0;
    flush = 1'b0;
    r_lat = 1;
    r_rdy_bad = 0;
    #2;
    while (!(done || fault) && r_lat < 60) begin
      if (mem_req && ready) r_rdy_bad = 1;
      if (fl_ack && mem_ack) flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      #2;
      r_lat++;
    end
    r_done = done; r_fault = fault; r_code = fcode; r_phys = phys;
    r_dbl = done && fault;
    @(negedge clk);
    #2;
    if (done || fault) r_dbl = 1;
    r_reads = rd_cnt - r0;
  endtask

  task automatic exp_done(input string tag, input logic [18:0] ph, input int rd, input int lat);
    chk(r_done && !r_fault && !r_notready, {tag, " done"}, {r_fault, r_done}, 1);
    chk(r_phys == ph, {tag, " phys"}, r_phys, ph);
    chk(r_reads == rd, {tag, " reads"}, r_reads, rd);
    chk(r_lat == lat, {tag, " latency"}, r_lat, lat);
    chk(!r_dbl, "R12 single strobe", r_dbl, 0);
    if (rd > 0) chk(!r_rdy_bad, "R9 ready low in walk", r_rdy_bad, 0);
  endtask

  task automatic exp_fault(input string tag, input logic [7:0] code, input int rd, input int lat);
    chk(r_fault && !r_done, {tag, " fault"}, {r_fault, r_done}, 2);
    chk(r_code == code, {tag, " code"}, r_code, code);
    chk(r_reads == rd, {tag, " reads"}, r_reads, rd);
    chk(r_lat == lat, {tag, " latency"}, r_lat, lat);
    chk(!r_dbl, "R12 single strobe", r_dbl, 0);
  endtask

  task automatic load(input logic [1:0] sel, input int len, input logic [18:0] base);
    logic [31:0] lw;
    lw = len;
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_data = {lw[6:0], base};
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    logic [17:0] e;
    logic [18:0] a;
    logic [31:0] pw;
    int off;
    bit ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(!done && !fault && !mem_req, "R1 idle outputs", {done, fault, mem_req}, 0);
    txn(1, 0, 3, 0, 0, 0, 0);
    exp_done("R1 empty base walk", {ent_r(19'h0)[8:0], 10'd3}, 1, 3);
    chk(last_addr == 19'h0, "R1 base cleared", last_addr, 0);

    load(2'd0, 63, ULO_B);
    load(2'd1, 63, UHI_B);
    load(2'd2, 63, EHI_B);
    do_flush();

    // R2 R4 R6 R7 user sweep: even page walks, odd partner hits
    for (int p = 0; p < 256; p++) begin
      off = (p * 37 + 5) & 1023;
      pw = off;
      e = ent_of(1, p);
      ev = (p % 2 == 0);
      txn(1, p, off, 0, 0, 0, 0);
      exp_done("R2 R6 R7 user sweep", {e[8:0], pw[9:0]}, ev ? 1 : 0, ev ? 3 : 1);
      if (ev) chk(last_addr == waddr(1, p), "R4 table word address", last_addr, waddr(1, p));
    end

    // R8 pure fetch on cached entries
    for (int p = 0; p < 256; p++) begin
      off = p & 1023;
      pw = off;
      e = ent_of(1, p);
      txn(1, p, off, 1, 1, 0, 0);
      if (e[17:16] == 2'b01) exp_done("R8 pure ok", {e[8:0], pw[9:0]}, 0, 1);
      else exp_fault("R8 pure bad", 8'h10, 0, 1);
    end
    for (int p = 0; p < 8; p++) begin
      e = ent_of(1, p);
      txn(1, p, 9, p[0], !p[0], 0, 0);
      exp_done("R8 check skipped", {e[8:0], 10'd9}, 0, 1);
    end

    // R3 executive pass-through with paging off
    exec_en = 1'b0;
    for (int p = 0; p < 256; p++) begin
      off = (p * 11 + 1) & 1023;
      pw = off;
      a = {1'b0, p[7:0], pw[9:0]};
      txn(0, p, off, 0, 0, 0, 0);
      exp_done("R3 exec map off", a, 0, 1);
    end
    // R3 R4 executive with paging on
    exec_en = 1'b1;
    for (int p = 0; p < 256; p++) begin
      off = (p * 13 + 2) & 1023;
      pw = off;
      if (p < 128) begin
        txn(0, p, off, 0, 0, 0, 0);
        exp_done("R3 exec low direct", {1'b0, p[7:0], pw[9:0]}, 0, 1);
      end else begin
        e = ent_of(0, p);
        ev = (p % 2 == 0);
        txn(0, p, off, 0, 0, 0, 0);
        exp_done("R4 exec high", {e[8:0], pw[9:0]}, ev ? 1 : 0, ev ? 3 : 1);
        if (ev) chk(last_addr == waddr(0, p), "R4 exec word address", last_addr, waddr(0, p));
      end
    end

    // R10 flush empties both caches; R8 on a walked entry
    do_flush();
    txn(1, 2, 0, 1, 1, 0, 0);
    exp_fault("R10 R8 refetch after flush", 8'h10, 1, 3);
    e = ent_of(1, 3);
    txn(1, 3, 4, 1, 1, 0, 0);
    exp_done("R7 partner hit pure ok", {e[8:0], 10'd4}, 0, 1);
    e = ent_of(0, 130);
    txn(0, 130, 6, 0, 0, 0, 0);
    exp_done("R10 exec refetch", {e[8:0], 10'd6}, 1, 3);

    // R5 length bound
    do_flush();
    load(2'd0, 5, ULO_B);
    txn(1, 12, 0, 0, 0, 0, 0);
    exp_fault("R5 index over length", 8'h80, 0, 1);
    e = ent_of(1, 10);
    txn(1, 10, 1, 0, 0, 0, 0);
    exp_done("R5 index equal length", {e[8:0], 10'd1}, 1, 3);
    load(2'd0, 0, ULO_B);
    e = ent_of(1, 11);
    txn(1, 11, 2, 0, 0, 0, 0);
    exp_done("R7 hit skips length", {e[8:0], 10'd2}, 0, 1);
    txn(1, 12, 0, 0, 0, 0, 0);
    exp_fault("R5 still over length", 8'h80, 0, 1);

    // R4 code 3 load is ignored
    load(2'd3, 63, 19'h07000);
    load(2'd0, 63, ULO_B);
    do_flush();
    txn(1, 2, 0, 0, 0, 0, 0);
    chk(last_addr == ULO_B + 19'd1, "R4 code3 ignored ulo", last_addr, ULO_B + 19'd1);
    txn(1, 130, 0, 0, 0, 0, 0);
    chk(last_addr == UHI_B + 19'd1, "R4 code3 ignored uhi", last_addr, UHI_B + 19'd1);
    txn(0, 132, 0, 0, 0, 0, 0);
    chk(last_addr == EHI_B + 19'd2, "R4 code3 ignored ehi", last_addr, EHI_B + 19'd2);

    // R11 flush with accept forces a walk
    e = ent_of(1, 2);
    txn(1, 2, 7, 0, 0, 1, 0);
    exp_done("R11 flush at accept", {e[8:0], 10'd7}, 1, 3);
    e = ent_of(1, 3);
    txn(1, 3, 7, 0, 0, 0, 0);
    exp_done("R11 refill after flush", {e[8:0], 10'd7}, 0, 1);

    // R11 flush in the acknowledge cycle drops the refill
    e = ent_of(1, 40);
    txn(1, 40, 8, 0, 0, 0, 1);
    exp_done("R11 flush at ack result", {e[8:0], 10'd8}, 1, 3);
    e = ent_of(1, 41);
    txn(1, 41, 8, 0, 0, 0, 0);
    exp_done("R11 partner not kept", {e[8:0], 10'd8}, 1, 3);
    e = ent_of(1, 40);
    txn(1, 40, 9, 0, 0, 0, 0);
    exp_done("R9 R7 hit after rewalk", {e[8:0], 10'd9}, 0, 1);

    summary();
    $finish;
  end
endmodule